// File: doc/BRIEF.md
# System Control Register Block

This block is the system control space of a small processor core: a handful of 32-bit registers on a simple word-addressed bus. The registers are a fixed identification word, a status register, a key-protected reset register and a low-power register. The status register holds software-set pending flags for three exceptions: the deferred service exception, the timer tick exception and the non-maskable interrupt. It also shows live exception status supplied by the prioritisation logic next to the block. The reset register produces one-cycle request pulses, and it only responds when the write carries the unlock key.

Software writes set bits and clear bits to control the pending flags. The flags leave the block as pend requests. The exception engine asserts a per-exception acknowledge input on handler entry, and that acknowledge clears the matching flag. Reads are combinational from the word index. Each byte strobe gates the byte lane it belongs to.

Top module: `sysctl_regs`

## Requirements
- R1: Word index 0 (byte offset 0x00) always reads 0x410CC200, and writes to it change nothing.
- R2: After reset all pend outputs are low and reset-request pulses are low. Word index 1 reads 0x00000000 when the status inputs are zero, word index 3 reads 0xFA050000 and word index 4 reads 0x00000000.
- R3: A write to word index 1 with bit 28 set sets the deferred service flag. Bit 27 clears it. The flag drives pend_dsrv and reads back at bit 28 from the cycle after the write.
- R4: In word index 1, bit 26 sets the timer tick flag and bit 25 clears it. The flag drives pend_tick and reads back at bit 26.
- R5: In word index 1, bit 31 sets the non-maskable interrupt flag. The flag drives pend_nmi and reads back at bit 31. Software has no bit that clears it.
- R6: A single write that holds both the set bit and the clear bit of one flag leaves that flag unchanged.
- R7: An acknowledge input clears its flag on the next edge. If a set write arrives in the same cycle, the set wins.
- R8: Word index 1 reads exc_active in bits [5:0], exc_preempted in bit 11, exc_pend_vec in bits [20:12] and exc_any_pend in bit 22. Clear bits and unlisted bits read 0.
- R9: A write to word index 3 takes effect only if bits [31:16] equal 0x05FA and strobes 3 and 2 are both set. Any other write is ignored completely. The register always reads 0xFA05 in bits [31:16] and zero in all other bits.
- R10: A keyed write with bit 2 set raises sys_reset_req for exactly the one cycle after the write. With bit 1 set, it raises clr_active_req in the same way. Both bits need strobe 0.
- R11: Word index 4 holds bits 1, 2 and 4, which drive lp_exit_sleep, lp_deep and lp_wake_on_pend. All other bits read 0.
- R12: Reserved word indices (2, 5 and above) read zero and ignore writes. In word index 1, a write with strobe 3 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Word index into the block (byte offset / 4) |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, bit i gates bits [8i+7:8i] |
| bus_rdata | output | 32 | Combinational read data |
| exc_active | input | 6 | Number of the exception being serviced |
| exc_preempted | input | 1 | A preempted active exception exists |
| exc_pend_vec | input | 9 | Highest-priority pending exception number |
| exc_any_pend | input | 1 | Some interrupt is pending |
| ack_dsrv | input | 1 | Handler entry for deferred service exception |
| ack_tick | input | 1 | Handler entry for timer tick exception |
| ack_nmi | input | 1 | Handler entry for non-maskable interrupt |
| pend_dsrv | output | 1 | Deferred service pend request |
| pend_tick | output | 1 | Timer tick pend request |
| pend_nmi | output | 1 | Non-maskable interrupt pend request |
| sys_reset_req | output | 1 | One-cycle system reset request |
| clr_active_req | output | 1 | One-cycle clear-active request |
| lp_exit_sleep | output | 1 | Sleep again when the handler returns |
| lp_deep | output | 1 | Deep sleep select |
| lp_wake_on_pend | output | 1 | Pending event wakes the core |

## Verification
The hardest case is an acknowledge and a set write landing on the same edge. The bench drives ack_dsrv high in the same cycle as a write with bit 28 set, then confirms that the flag is still set. Keyed-write rejection is also exercised from several directions: a wrong key, a correct key with a missing upper strobe, and a correct key with strobe 0 missing. The bench watches the pulse outputs in the cycle where a pulse would appear and in the cycle after.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 32;
  localparam int ACT_W = 6;
  localparam int VEC_W = 9;
  localparam logic [DW-1:0] ID_WORD    = 32'h410C_C200;
  localparam logic [15:0]   UNLOCK_KEY = 16'h05FA;

  localparam int IDX_ID    = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_KEYED = 3;
  localparam int IDX_LP    = 4;

  // status register bit positions
  localparam int B_NMI_SET  = 31;
  localparam int B_DSRV_SET = 28;
  localparam int B_DSRV_CLR = 27;
  localparam int B_TICK_SET = 26;
  localparam int B_TICK_CLR = 25;
  localparam int B_ANY      = 22;
  localparam int B_VEC_LO   = 12;
  localparam int B_PREEMPT  = 11;

  // flag slots
  localparam int F_DSRV = 0;
  localparam int F_TICK = 1;
  localparam int F_NMI  = 2;
  localparam int NUM_FLAGS = 3;

  function automatic logic [DW-1:0] status_word(
      input logic [NUM_FLAGS-1:0] flags,
      input logic any, input logic [VEC_W-1:0] vec,
      input logic preempt, input logic [ACT_W-1:0] act);
    logic [DW-1:0] w;
    w = '0;
    w[B_NMI_SET]  = flags[F_NMI];
    w[B_DSRV_SET] = flags[F_DSRV];
    w[B_TICK_SET] = flags[F_TICK];
    w[B_ANY]      = any;
    w[B_VEC_LO +: VEC_W] = vec;
    w[B_PREEMPT]  = preempt;
    w[ACT_W-1:0]  = act;
    return w;
  endfunction

  function automatic logic [DW-1:0] keyed_readback();
    return {~UNLOCK_KEY, 16'h0000};
  endfunction

  function automatic logic key_accepted(input logic [DW-1:0] wd, input logic [3:0] be);
    return be[3] && be[2] && (wd[31:16] == UNLOCK_KEY);
  endfunction
endpackage

// File: rtl/sysctl_pend_cell.sv
module sysctl_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic ack,
  output logic q
);
  logic set_only, clr_only;
  assign set_only = set_req && !clr_req;
  assign clr_only = clr_req && !set_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (set_only) q <= 1'b1;
    else if (clr_only || (ack && !set_req)) q <= 1'b0;
  end

  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !clr_req) |=> q);
  a_r6_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && clr_req && !ack) |=> $stable(q));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_req) |=> !q);
endmodule

// File: rtl/sysctl_keyed.sv
module sysctl_keyed
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [3:0]    be,
  output logic          key_ok,
  output logic          sys_reset_req,
  output logic          clr_active_req
);
  logic accept;
  logic unused_wbits;
  assign unused_wbits = ^{wdata[15:3], wdata[0], be[1]};
  assign key_ok = key_accepted(wdata, be);
  assign accept = wr_en && key_ok && be[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_reset_req  <= 1'b0;
      clr_active_req <= 1'b0;
    end else begin
      sys_reset_req  <= accept && wdata[2];
      clr_active_req <= accept && wdata[1];
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);
  a_r10_clr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active_req |=> !clr_active_req);
  a_r9_reject_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_ok) |=> (!sys_reset_req && !clr_active_req));
endmodule

// File: rtl/sysctl_lowpower.sv
module sysctl_lowpower (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wbits,
  output logic [2:0] lp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lp_q <= '0;
    else if (wr_en) lp_q <= wbits;
  end

  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lp_q));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [3:0]       bus_be,
  output logic [DW-1:0]    bus_rdata,
  input  logic [ACT_W-1:0] exc_active,
  input  logic             exc_preempted,
  input  logic [VEC_W-1:0] exc_pend_vec,
  input  logic             exc_any_pend,
  input  logic             ack_dsrv,
  input  logic             ack_tick,
  input  logic             ack_nmi,
  output logic             pend_dsrv,
  output logic             pend_tick,
  output logic             pend_nmi,
  output logic             sys_reset_req,
  output logic             clr_active_req,
  output logic             lp_exit_sleep,
  output logic             lp_deep,
  output logic             lp_wake_on_pend
);
  logic wr_stat, wr_keyed, wr_lp, key_ok;
  logic [NUM_FLAGS-1:0] set_v, clr_v, ack_v, flag_q;
  logic [2:0] lp_q;

  assign wr_stat  = bus_we && (bus_addr == ADDR_W'(IDX_STAT)) && bus_be[3];
  assign wr_keyed = bus_we && (bus_addr == ADDR_W'(IDX_KEYED));
  assign wr_lp    = bus_we && (bus_addr == ADDR_W'(IDX_LP)) && bus_be[0];

  assign set_v[F_DSRV] = wr_stat && bus_wdata[B_DSRV_SET];
  assign clr_v[F_DSRV] = wr_stat && bus_wdata[B_DSRV_CLR];
  assign set_v[F_TICK] = wr_stat && bus_wdata[B_TICK_SET];
  assign clr_v[F_TICK] = wr_stat && bus_wdata[B_TICK_CLR];
  assign set_v[F_NMI]  = wr_stat && bus_wdata[B_NMI_SET];
  assign clr_v[F_NMI]  = 1'b0;
  assign ack_v = {ack_nmi, ack_tick, ack_dsrv};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sysctl_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_req(set_v[i]), .clr_req(clr_v[i]),
      .ack(ack_v[i]), .q(flag_q[i]));
  end

  assign pend_dsrv = flag_q[F_DSRV];
  assign pend_tick = flag_q[F_TICK];
  assign pend_nmi  = flag_q[F_NMI];

  sysctl_keyed u_keyed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_keyed), .wdata(bus_wdata), .be(bus_be),
    .key_ok(key_ok), .sys_reset_req(sys_reset_req), .clr_active_req(clr_active_req));

  sysctl_lowpower u_lp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_lp),
    .wbits({bus_wdata[4], bus_wdata[2], bus_wdata[1]}), .lp_q(lp_q));

  assign lp_exit_sleep   = lp_q[0];
  assign lp_deep         = lp_q[1];
  assign lp_wake_on_pend = lp_q[2];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(IDX_ID):    bus_rdata = ID_WORD;
      ADDR_W'(IDX_STAT):  bus_rdata = status_word(flag_q, exc_any_pend, exc_pend_vec,
                                                  exc_preempted, exc_active);
      ADDR_W'(IDX_KEYED): bus_rdata = keyed_readback();
      ADDR_W'(IDX_LP):    bus_rdata = {27'd0, lp_q[2], 1'b0, lp_q[1], lp_q[0], 1'b0};
      default:            bus_rdata = '0;
    endcase
  end

  a_r9_ignored_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_keyed && !key_ok) |=> !sys_reset_req);
  a_r5_nmi_no_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_nmi && !ack_nmi) |=> pend_nmi);
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [3:0] bus_be = 0;
  logic [31:0] bus_rdata;
  logic [5:0] exc_active = 0;
  logic exc_preempted = 0;
  logic [8:0] exc_pend_vec = 0;
  logic exc_any_pend = 0;
  logic ack_dsrv = 0, ack_tick = 0, ack_nmi = 0;
  logic pend_dsrv, pend_tick, pend_nmi, sys_reset_req, clr_active_req;
  logic lp_exit_sleep, lp_deep, lp_wake_on_pend;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  logic rd_valid = 0;

  always #4 clk = ~clk;

  sysctl_regs u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: bus write
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1; bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_we = 0; bus_be = 0;
  endtask

  // driver: read, pushes expected item for the monitor
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    rd_valid = 1;
    @(negedge clk); #1;
    rd_valid = 0;
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (rd_valid) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, bus_rdata, it.exp);
    end
  end

  function automatic logic [31:0] exp_status(input bit nmi, input bit ds, input bit tk,
      input bit any, input int vec, input bit pre, input int act);
    return (nmi ? 32'h8000_0000 : 0) + (ds ? 32'h1000_0000 : 0) + (tk ? 32'h0400_0000 : 0)
         + (any ? 32'h0040_0000 : 0) + vec * 4096 + (pre ? 2048 : 0) + act;
  endfunction

  task automatic ack_pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) ack_dsrv = 1; else if (which == 1) ack_tick = 1; else ack_nmi = 1;
    @(posedge clk); #1;
    ack_dsrv = 0; ack_tick = 0; ack_nmi = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2 reset state
    chk("R2 pend_dsrv", {31'd0, pend_dsrv}, 0);
    chk("R2 pend_tick", {31'd0, pend_tick}, 0);
    chk("R2 pend_nmi", {31'd0, pend_nmi}, 0);
    chk("R2 reset pulse", {31'd0, sys_reset_req}, 0);
    rd(0, 32'h410CC200, "R1 id");
    rd(1, 0, "R2 status reset");
    rd(3, 32'hFA050000, "R2 keyed reset");
    rd(4, 0, "R2 lowpower reset");
    // R1 write ignored
    wr(0, 32'hFFFFFFFF, 4'hF);
    rd(0, 32'h410CC200, "R1 id after write");
    // R3
    wr(1, 32'h1000_0000, 4'hF);
    chk("R3 pend_dsrv set", {31'd0, pend_dsrv}, 1);
    rd(1, exp_status(0,1,0,0,0,0,0), "R3 readback");
    // R4
    wr(1, 32'h0400_0000, 4'hF);
    chk("R4 pend_tick set", {31'd0, pend_tick}, 1);
    rd(1, exp_status(0,1,1,0,0,0,0), "R4 readback");
    // R6 conflicts
    wr(1, 32'h1800_0000, 4'hF);
    wr(1, 32'h0600_0000, 4'hF);
    rd(1, exp_status(0,1,1,0,0,0,0), "R6 conflict unchanged");
    // R3 clear
    wr(1, 32'h0800_0000, 4'hF);
    chk("R3 pend_dsrv cleared", {31'd0, pend_dsrv}, 0);
    rd(1, exp_status(0,0,1,0,0,0,0), "R3 clear readback");
    // R12 strobe 3 off
    wr(1, 32'h1000_0000, 4'h7);
    chk("R12 strobe gate", {31'd0, pend_dsrv}, 0);
    // R4 clear
    wr(1, 32'h0200_0000, 4'hF);
    chk("R4 pend_tick cleared", {31'd0, pend_tick}, 0);
    // R5 nmi
    wr(1, 32'h8000_0000, 4'hF);
    chk("R5 pend_nmi set", {31'd0, pend_nmi}, 1);
    wr(1, 32'h7E00_0000, 4'hF);
    chk("R5 dsrv conflict keeps 0", {31'd0, pend_dsrv}, 0);
    rd(1, exp_status(1,0,0,0,0,0,0), "R5 no sw clear");
    ack_pulse(2);
    chk("R7 ack clears nmi", {31'd0, pend_nmi}, 0);
    // R7 ack tick
    wr(1, 32'h0400_0000, 4'hF);
    ack_pulse(1);
    chk("R7 ack clears tick", {31'd0, pend_tick}, 0);
    // R7 set wins over ack same cycle
    @(posedge clk); #1;
    bus_addr = 1; bus_we = 1; bus_wdata = 32'h1000_0000; bus_be = 4'hF; ack_dsrv = 1;
    @(posedge clk); #1;
    bus_we = 0; ack_dsrv = 0;
    chk("R7 set beats ack", {31'd0, pend_dsrv}, 1);
    ack_pulse(0);
    chk("R7 ack clears dsrv", {31'd0, pend_dsrv}, 0);
    // R8 status fields
    exc_active = 6'h2A; exc_pend_vec = 9'h1A5; exc_any_pend = 1; exc_preempted = 1;
    rd(1, exp_status(0,0,0,1,'h1A5,1,'h2A), "R8 status fields");
    exc_active = 6'h01; exc_pend_vec = 9'h003; exc_any_pend = 0; exc_preempted = 0;
    rd(1, exp_status(0,0,0,0,3,0,1), "R8 status fields 2");
    // R9/R10 keyed
    wr(3, 32'h05FA_0004, 4'hF);
    chk("R10 reset pulse high", {31'd0, sys_reset_req}, 1);
    @(posedge clk); #1;
    chk("R10 reset pulse one cycle", {31'd0, sys_reset_req}, 0);
    rd(3, 32'hFA050000, "R9 readback");
    wr(3, 32'h05FB_0004, 4'hF);
    chk("R9 bad key ignored", {31'd0, sys_reset_req}, 0);
    wr(3, 32'h05FA_0004, 4'h7);
    chk("R9 missing strobe ignored", {31'd0, sys_reset_req}, 0);
    wr(3, 32'h05FA_0004, 4'hE);
    chk("R10 strobe0 needed", {31'd0, sys_reset_req}, 0);
    wr(3, 32'h05FA_0002, 4'hF);
    chk("R10 clr_active pulse", {31'd0, clr_active_req}, 1);
    chk("R10 no reset with clr", {31'd0, sys_reset_req}, 0);
    @(posedge clk); #1;
    chk("R10 clr_active one cycle", {31'd0, clr_active_req}, 0);
    // R11
    wr(4, 32'hFFFF_FFFF, 4'hF);
    chk("R11 outputs", {29'd0, lp_wake_on_pend, lp_deep, lp_exit_sleep}, 3'b111);
    rd(4, 32'h16, "R11 readback");
    wr(4, 32'h0000_0004, 4'hF);
    rd(4, 32'h04, "R11 partial");
    // R12 reserved
    wr(2, 32'hFFFF_FFFF, 4'hF);
    rd(2, 0, "R12 reserved 0x08");
    wr(5, 32'hFFFF_FFFF, 4'hF);
    rd(5, 0, "R12 reserved 0x14");
    rd(6, 0, "R12 reserved 0x18");
    rd(1, exp_status(0,0,0,0,3,0,1), "R12 status untouched");
    rd(4, 32'h04, "R12 lowpower untouched");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule